// File: doc/BRIEF.md
# Rail Enable Sequencer with Per-Rail Trigger Selection and Delay Timers

This block drives the enable pins of several voltage regulators. Each rail watches one general-purpose input that the system toggles. It can also require the power-good signals of some other rails before it turns on. When its condition becomes true, the rail waits a programmed number of millisecond ticks and then raises its enable. When the condition becomes false, it waits a second programmed number of ticks and then drops the enable. Rails that share one input can be given different delays, so a single toggle brings them up one after another and takes them down one after another.

Every rail has its own configuration register and its own tick counter. Configuration is written through a load port that stands in for a non-volatile store. The port is a write strobe, a rail index and the four fields to store. Each rail is run by a four-state machine:

- `RS_OFF`: the enable is low and the rail is idle.
- `RS_RAMP_UP`: the enable is low and the counter is counting toward turn-on.
- `RS_ON`: the enable is high and the rail is idle.
- `RS_RAMP_DN`: the enable is high and the counter is counting toward turn-off.

The machine moves between these states on six named transitions:

- `arm_up`: from `RS_OFF` to `RS_RAMP_UP`, taken when the condition rises and the rise delay is not zero.
- `fire_up`: to `RS_ON`, taken from `RS_RAMP_UP` when the count completes, or taken directly from `RS_OFF` when the rise delay is zero.
- `abort_up`: from `RS_RAMP_UP` back to `RS_OFF`, taken when the condition drops during the count.
- `arm_dn`, `fire_dn` and `abort_dn`: the same three moves in the opposite direction, using the fall delay.

Top module: `rail_seq`

## Requirements
- R1: During reset every enable is low. Reset clears every rail's configuration to input select 0, an empty power-good mask and zero delays. As a result, after reset each rail follows input 0 with no delay.
- R2: Configuration fields are stored only on a clock edge where `cfg_we` is high. A write presented with `cfg_we` low leaves the rail's behaviour unchanged.
- R3: With a rise delay D greater than 0, the enable goes high on the clock edge that samples the D-th `ms_tick` pulse after the condition became true, and no earlier.
- R4: A rail's condition uses only the input whose index equals its select field. Activity on any other input has no effect on that rail.
- R5: Bit j of a rail's power-good mask makes `rail_pg[j]` a required term of the condition. The condition is the selected input AND every masked power-good bit. Unmasked power-good bits are ignored.
- R6: With a fall delay D greater than 0, the enable goes low on the clock edge that samples the D-th `ms_tick` pulse after the condition became false.
- R7: A delay of zero changes the enable on the first clock edge after the condition changes, without waiting for any tick.
- R8: If the condition reverses while a count is pending, the count is discarded and the enable keeps its level. The next change of the condition starts a full new count.
- R9: Rails count independently. Three rails on one input with delays of 2, 4 and 6 ticks switch on at ticks 2, 4 and 6. With the same fall delays, they switch off at ticks 2, 4 and 6 after the input drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe that advances the delay counters |
| gpio_in | input | N_GPIO | Trigger inputs |
| rail_pg | input | N_RAILS | Power-good input of each rail |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rail | input | RAIL_W | Index of the rail being configured |
| cfg_gpio_sel | input | SEL_W | Index of the input the rail follows |
| cfg_pg_mask | input | N_RAILS | Power-good signals the rail requires |
| cfg_rise_dly | input | DLY_W | Turn-on delay in ticks |
| cfg_fall_dly | input | DLY_W | Turn-off delay in ticks |
| rail_en | output | N_RAILS | Regulator enable of each rail |

## Verification
Several properties are checked on every cycle:

- An enable never rises unless the rail's condition held on the cycle before, and never falls unless it was absent.
- With a nonzero delay, an enable changes only on a cycle that sampled a tick.
- With a zero delay, the enable follows the condition within one clock.
- The stored configuration does not move while the write strobe is low.

Some behaviour can only be shown by the bench's scenarios. These are the exact tick count at which each delay completes, the discarded count after a reversal, the 2/4/6 stagger in both directions, and the full sweeps of input select and power-good masks.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [1:0] {
        RS_OFF     = 2'd0,
        RS_RAMP_UP = 2'd1,
        RS_ON      = 2'd2,
        RS_RAMP_DN = 2'd3
    } rail_state_t;

endpackage

// File: rtl/rseq_cfg_bank.sv
module rseq_cfg_bank #(
    parameter int N_RAILS = 4,
    parameter int SEL_W   = 2,
    parameter int RAIL_W  = 2,
    parameter int DLY_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [RAIL_W-1:0]                 wr_rail,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [N_RAILS-1:0]                wr_mask,
    input  logic [DLY_W-1:0]                  wr_rise,
    input  logic [DLY_W-1:0]                  wr_fall,
    output logic [N_RAILS-1:0][SEL_W-1:0]     sel_q,
    output logic [N_RAILS-1:0][N_RAILS-1:0]   mask_q,
    output logic [N_RAILS-1:0][DLY_W-1:0]     rise_q,
    output logic [N_RAILS-1:0][DLY_W-1:0]     fall_q
);

    for (genvar r = 0; r < N_RAILS; r++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_rail == RAIL_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[r]  <= '0;
                mask_q[r] <= '0;
                rise_q[r] <= '0;
                fall_q[r] <= '0;
            end else if (hit) begin
                sel_q[r]  <= wr_sel;
                mask_q[r] <= wr_mask;
                rise_q[r] <= wr_rise;
                fall_q[r] <= wr_fall;
            end
        end
    end

endmodule

// File: rtl/rseq_cond.sv
module rseq_cond #(
    parameter int N_RAILS = 4,
    parameter int N_GPIO  = 4,
    parameter int SEL_W   = 2
) (
    input  logic [N_GPIO-1:0]                gpio,
    input  logic [N_RAILS-1:0]               pg,
    input  logic [N_RAILS-1:0][SEL_W-1:0]    sel,
    input  logic [N_RAILS-1:0][N_RAILS-1:0]  mask,
    output logic [N_RAILS-1:0]               want
);

    localparam logic [SEL_W:0] GPIO_LIM = (SEL_W+1)'(N_GPIO);

    for (genvar r = 0; r < N_RAILS; r++) begin : g_term
        logic trig_bit;
        logic pg_ok;

        always_comb begin
            trig_bit = 1'b0;
            if ({1'b0, sel[r]} < GPIO_LIM) begin
                trig_bit = gpio[sel[r]];
            end
            pg_ok   = ((pg & mask[r]) == mask[r]);
            want[r] = trig_bit && pg_ok;
        end
    end

endmodule

// File: rtl/rseq_rail_fsm.sv
module rseq_rail_fsm
    import rseq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             want,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             en
);

    rail_state_t      state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [DLY_W:0]   cnt_inc;
    logic             rise_done, fall_done;

    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign rise_done = (rise_dly == '0) || (tick && (cnt_inc >= {1'b0, rise_dly}));
    assign fall_done = (fall_dly == '0) || (tick && (cnt_inc >= {1'b0, fall_dly}));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: arm_up, fire_up, abort_up, arm_dn, fire_dn, abort_dn
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_OFF: begin
                if (want) begin
                    state_d = (rise_dly == '0) ? RS_ON : RS_RAMP_UP;
                end
            end
            RS_RAMP_UP: begin
                if (!want) begin
                    state_d = RS_OFF;
                end else if (rise_done) begin
                    state_d = RS_ON;
                end
            end
            RS_ON: begin
                if (!want) begin
                    state_d = (fall_dly == '0) ? RS_OFF : RS_RAMP_DN;
                end
            end
            RS_RAMP_DN: begin
                if (want) begin
                    state_d = RS_ON;
                end else if (fall_done) begin
                    state_d = RS_OFF;
                end
            end
            default: state_d = RS_OFF;
        endcase
    end

    // tick counter: cleared on every entry into a ramp state
    always_comb begin
        cnt_d = '0;
        if ((state_q == RS_RAMP_UP && state_d == RS_RAMP_UP) ||
            (state_q == RS_RAMP_DN && state_d == RS_RAMP_DN)) begin
            cnt_d = tick ? cnt_inc[DLY_W-1:0] : cnt_q;
        end
    end

    // outputs
    always_comb begin
        en = (state_q == RS_ON) || (state_q == RS_RAMP_DN);
    end

endmodule

// File: rtl/rail_seq.sv
module rail_seq #(
    parameter int N_RAILS = 4,
    parameter int N_GPIO  = 4,
    parameter int DLY_W   = 8,
    localparam int SEL_W  = (N_GPIO  > 1) ? $clog2(N_GPIO)  : 1,
    localparam int RAIL_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic [N_GPIO-1:0]  gpio_in,
    input  logic [N_RAILS-1:0] rail_pg,
    input  logic               cfg_we,
    input  logic [RAIL_W-1:0]  cfg_rail,
    input  logic [SEL_W-1:0]   cfg_gpio_sel,
    input  logic [N_RAILS-1:0] cfg_pg_mask,
    input  logic [DLY_W-1:0]   cfg_rise_dly,
    input  logic [DLY_W-1:0]   cfg_fall_dly,
    output logic [N_RAILS-1:0] rail_en
);

    logic [N_RAILS-1:0][SEL_W-1:0]   sel_w;
    logic [N_RAILS-1:0][N_RAILS-1:0] mask_w;
    logic [N_RAILS-1:0][DLY_W-1:0]   rise_w;
    logic [N_RAILS-1:0][DLY_W-1:0]   fall_w;
    logic [N_RAILS-1:0]              want_w;

    rseq_cfg_bank #(
        .N_RAILS(N_RAILS), .SEL_W(SEL_W), .RAIL_W(RAIL_W), .DLY_W(DLY_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_rail (cfg_rail),
        .wr_sel  (cfg_gpio_sel),
        .wr_mask (cfg_pg_mask),
        .wr_rise (cfg_rise_dly),
        .wr_fall (cfg_fall_dly),
        .sel_q   (sel_w),
        .mask_q  (mask_w),
        .rise_q  (rise_w),
        .fall_q  (fall_w)
    );

    rseq_cond #(
        .N_RAILS(N_RAILS), .N_GPIO(N_GPIO), .SEL_W(SEL_W)
    ) u_cond (
        .gpio (gpio_in),
        .pg   (rail_pg),
        .sel  (sel_w),
        .mask (mask_w),
        .want (want_w)
    );

    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        rseq_rail_fsm #(.DLY_W(DLY_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ms_tick),
            .want     (want_w[r]),
            .rise_dly (rise_w[r]),
            .fall_dly (fall_w[r]),
            .en       (rail_en[r])
        );
    end

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
    parameter int N_RAILS = 4,
    parameter int SEL_W   = 2,
    parameter int DLY_W   = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              ms_tick,
    input logic                              cfg_we,
    input logic [N_RAILS-1:0]                rail_en,
    input logic [N_RAILS-1:0]                want,
    input logic [N_RAILS-1:0][SEL_W-1:0]     sel,
    input logic [N_RAILS-1:0][N_RAILS-1:0]   mask,
    input logic [N_RAILS-1:0][DLY_W-1:0]     rise,
    input logic [N_RAILS-1:0][DLY_W-1:0]     fall
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r1: assert (rail_en == '0)
                else $error("enable high during reset");
        end
    end

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(sel) && $stable(mask) && $stable(rise) && $stable(fall)));

    for (genvar r = 0; r < N_RAILS; r++) begin : g_chk
        p_rise_needs_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[r]) |-> $past(want[r]));

        p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rail_en[r]) && ($past(rise[r]) != '0)) |-> $past(ms_tick));

        p_fall_needs_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rail_en[r]) |-> !$past(want[r]));

        p_fall_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(rail_en[r]) && ($past(fall[r]) != '0)) |-> $past(ms_tick));

        p_zero_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!rail_en[r] && want[r] && (rise[r] == '0)) |=> rail_en[r]);

        p_zero_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rail_en[r] && !want[r] && (fall[r] == '0)) |=> !rail_en[r]);
    end

endmodule

bind rail_seq rail_seq_chk #(
    .N_RAILS(N_RAILS), .SEL_W(SEL_W), .DLY_W(DLY_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .cfg_we  (cfg_we),
    .rail_en (rail_en),
    .want    (want_w),
    .sel     (sel_w),
    .mask    (mask_w),
    .rise    (rise_w),
    .fall    (fall_w)
);

// File: tb/rail_seq_test.sv
module rail_seq_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [3:0] gpio_in = 4'hF;
    logic [3:0] rail_pg = 4'hF;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_rail = '0;
    logic [1:0] cfg_gpio_sel = '0;
    logic [3:0] cfg_pg_mask = '0;
    logic [7:0] cfg_rise_dly = '0;
    logic [7:0] cfg_fall_dly = '0;
    logic [3:0] rail_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_seq uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .gpio_in(gpio_in),
        .rail_pg(rail_pg), .cfg_we(cfg_we), .cfg_rail(cfg_rail),
        .cfg_gpio_sel(cfg_gpio_sel), .cfg_pg_mask(cfg_pg_mask),
        .cfg_rise_dly(cfg_rise_dly), .cfg_fall_dly(cfg_fall_dly),
        .rail_en(rail_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int r, input int s, input int m,
                             input int rd, input int fd, input bit we);
        @(negedge clk);
        cfg_rail     = 2'(r);
        cfg_gpio_sel = 2'(s);
        cfg_pg_mask  = 4'(m);
        cfg_rise_dly = 8'(rd);
        cfg_fall_dly = 8'(fd);
        cfg_we       = we;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic clk1();
        @(negedge clk);
    endtask

    task automatic park_all();
        for (int r = 0; r < 4; r++) cfg_write(r, 3, 0, 0, 0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds enables low, then cleared config follows input 0 at once
        repeat (3) begin
            clk1();
            check("R1 reset enables low", 32'(rail_en), 32'h0);
        end
        gpio_in = 4'b0001;
        rail_pg = 4'b0000;
        rst_n   = 1'b1;
        clk1();
        check("R1 cleared config follows input0", 32'(rail_en), 32'hF);
        gpio_in = 4'b0000;
        clk1();
        check("R1 cleared config drop", 32'(rail_en), 32'h0);

        park_all();

        // R4: select sweep on rail 0
        for (int s = 0; s < 4; s++) begin
            cfg_write(0, s, 0, 0, 0, 1'b1);
            for (int g = 0; g < 4; g++) begin
                gpio_in = 4'(1 << g);
                clk1();
                check("R4 select follows", 32'(rail_en[0]), 32'(g == s));
                gpio_in = 4'b0000;
                clk1();
                check("R4 select idle", 32'(rail_en[0]), 32'h0);
            end
        end

        // R5: power-good mask sweep on rail 0
        gpio_in = 4'b0001;
        for (int m = 0; m < 16; m++) begin
            cfg_write(0, 0, m, 0, 0, 1'b1);
            for (int p = 0; p < 16; p++) begin
                rail_pg = 4'(p);
                clk1();
                check("R5 pg gating", 32'(rail_en[0]), 32'(((p & m) == m)));
            end
        end
        gpio_in = 4'b0000;
        rail_pg = 4'b0000;
        park_all();
        clk1();

        // R3 and R7: rise delay sweep on rail 1
        for (int d = 0; d < 6; d++) begin
            cfg_write(1, 1, 0, d, 0, 1'b1);
            gpio_in = 4'b0010;
            if (d == 0) begin
                clk1();
                check("R7 zero rise immediate", 32'(rail_en[1]), 32'h1);
            end else begin
                for (int k = 1; k <= d; k++) begin
                    pulse_tick();
                    check("R3 rise after D ticks", 32'(rail_en[1]), 32'(k == d));
                end
            end
            gpio_in = 4'b0000;
            clk1();
            check("R7 zero fall immediate", 32'(rail_en[1]), 32'h0);
        end

        // R6: fall delay sweep on rail 1
        for (int d = 1; d < 6; d++) begin
            cfg_write(1, 1, 0, 0, d, 1'b1);
            gpio_in = 4'b0010;
            clk1();
            check("R6 rail on before fall", 32'(rail_en[1]), 32'h1);
            gpio_in = 4'b0000;
            for (int k = 1; k <= d; k++) begin
                pulse_tick();
                check("R6 fall after D ticks", 32'(rail_en[1]), 32'(k != d));
            end
        end

        // R8: reversal during a pending count
        cfg_write(2, 2, 0, 3, 3, 1'b1);
        gpio_in = 4'b0100;
        pulse_tick();
        pulse_tick();
        check("R8 rise pending", 32'(rail_en[2]), 32'h0);
        gpio_in = 4'b0000;
        clk1();
        check("R8 abort keeps low", 32'(rail_en[2]), 32'h0);
        gpio_in = 4'b0100;
        pulse_tick();
        pulse_tick();
        check("R8 rise count restarted", 32'(rail_en[2]), 32'h0);
        pulse_tick();
        check("R8 rise full count", 32'(rail_en[2]), 32'h1);
        gpio_in = 4'b0000;
        pulse_tick();
        pulse_tick();
        check("R8 fall pending", 32'(rail_en[2]), 32'h1);
        gpio_in = 4'b0100;
        clk1();
        check("R8 abort keeps high", 32'(rail_en[2]), 32'h1);
        gpio_in = 4'b0000;
        pulse_tick();
        pulse_tick();
        check("R8 fall count restarted", 32'(rail_en[2]), 32'h1);
        pulse_tick();
        check("R8 fall full count", 32'(rail_en[2]), 32'h0);

        // R2: write with strobe low is ignored
        cfg_write(1, 1, 0, 0, 0, 1'b1);
        cfg_write(1, 2, 0, 5, 5, 1'b0);
        gpio_in = 4'b0010;
        clk1();
        check("R2 ignored write keeps select and delay", 32'(rail_en[1]), 32'h1);
        gpio_in = 4'b0100;
        clk1();
        check("R2 ignored write select unchanged", 32'(rail_en[1]), 32'h0);
        gpio_in = 4'b0000;
        clk1();

        // R9: three rails staggered on one input
        cfg_write(0, 0, 0, 2, 2, 1'b1);
        cfg_write(1, 0, 0, 4, 4, 1'b1);
        cfg_write(2, 0, 0, 6, 6, 1'b1);
        cfg_write(3, 3, 0, 0, 0, 1'b1);
        gpio_in = 4'b0001;
        for (int k = 1; k <= 6; k++) begin
            pulse_tick();
            check("R9 staggered up", 32'(rail_en),
                  32'((k >= 2) | ((k >= 4) << 1) | ((k >= 6) << 2)));
        end
        gpio_in = 4'b0000;
        for (int k = 1; k <= 6; k++) begin
            pulse_tick();
            check("R9 staggered down", 32'(rail_en),
                  32'((k < 2) | ((k < 4) << 1) | ((k < 6) << 2)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule